// File: doc/BRIEF.md
# Direct-Mapped Data Cache Controller

This block is a small direct-mapped data cache that sits between a processor request port and a line-wide memory port. The processor presents a request with a valid/ready handshake: a byte address, a read/write flag, one line of write data and per-byte enables. Every request gets exactly one pulse on `rsp_valid_o`. For reads, the line data comes with that pulse. For writes, the pulse only acknowledges the request. The memory side moves whole lines. Its request channel has a valid/ready handshake, and reads return data one or more cycles later on `mem_rsp_valid_i`.

The address divides into three fields. From the top down they are a tag, a line index and a byte offset. The index picks a single line. That line is the only one checked for a hit and the only one replaced on a miss. Two static parameters set the write policy:

- `WRITE_BACK` chooses between write-back with per-line dirty tracking and write-through.
- `WRITE_ALLOC` chooses whether a write miss fills the line or goes around the cache.

Two counters report the number of accepted requests and the number of misses, so a miss rate can be compared against a model.

Top module: `dm_cache_ctrl`

## Requirements
- R1: After reset, `req_ready_o` is 1, both counters are 0, no memory request is pending, and every line is invalid, so the first access to any address misses.
- R2: A request hits only when the line at its index is valid and its stored tag equals the request tag. An address with the same index but a different tag misses and replaces that line.
- R3: A read hit raises `rsp_valid_o` with the line data in the cycle after the request is accepted. Each request gets exactly one response cycle.
- R4: With write-back, a write hit completes two cycles after acceptance. Only the bytes whose enable bit `req_be_i[b]` is 1 change, where bit b covers data bits 8b+7..8b.
- R5: With write-back, a write hit causes no memory traffic and marks the line dirty. On a miss, a dirty victim is first written to memory as a full line with all enables set, and only then is the new line fetched. A clean victim is dropped without a memory write.
- R6: With write-through, every write issues one memory write carrying the request's byte enables. This happens after the cache update on a hit. No line is ever written back on eviction.
- R7: With write-allocate, a write miss fills the line from memory and then completes as a write hit.
- R8: With no-write-allocate, a write miss goes only to memory. The cache line at that index keeps its previous contents and tag.
- R9: `req_ready_o` is 0 whenever a memory request is outstanding. A memory request that is not accepted keeps its address, direction and data unchanged in the next cycle.
- R10: The access counter increments once per accepted request. The miss counter increments once per request that misses, and counts neither the refill retry nor anything else.
- R11: Read data always equals the latest value written by the processor to that line, merged byte by byte over the initial memory contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Processor request valid |
| req_ready_o | output | 1 | Controller can accept a request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Byte address |
| req_wdata_i | input | 8*LINE_BYTES | Write data, one line |
| req_be_i | input | LINE_BYTES | Byte enables for writes |
| rsp_valid_o | output | 1 | One-cycle response pulse |
| rsp_rdata_o | output | 8*LINE_BYTES | Read data, valid with `rsp_valid_o` on reads |
| mem_req_valid_o | output | 1 | Memory request valid |
| mem_req_ready_i | input | 1 | Memory accepts request |
| mem_req_write_o | output | 1 | 1 = memory write, 0 = line read |
| mem_req_addr_o | output | ADDR_W | Line-aligned memory address |
| mem_req_wdata_o | output | 8*LINE_BYTES | Memory write data |
| mem_req_be_o | output | LINE_BYTES | Memory write byte enables |
| mem_rsp_valid_i | input | 1 | Read data valid from memory |
| mem_rsp_rdata_i | input | 8*LINE_BYTES | Line read data from memory |
| acc_cnt_o | output | CNT_W | Accepted request count |
| miss_cnt_o | output | CNT_W | Miss count |

## Verification
The hardest case to reach is a miss whose victim is dirty. It needs an earlier write hit on one tag, followed by a request with the same index and a different tag. It must also be shown to produce exactly one full-line write before the refill, while a clean victim produces none. The stimulus limits addresses to 64 lines over 16 indices, so random traffic produces frequent conflicts and dirty evictions. Directed sequences on both a write-back/allocate instance and a write-through/no-allocate instance cover these cases: dirty versus clean eviction, a write miss that bypasses the cache, and a hit on the untouched line afterwards. A memory model with random ready and random response delay stresses the hold rules on the memory port.

// File: rtl/dm_cache_pkg.sv
package dm_cache_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_COMPARE,
    ST_WRITEBACK,
    ST_FILL,
    ST_RESPOND,
    ST_MEMWR
  } cc_state_e;
endpackage

// File: rtl/dm_cache_tag_store.sv
module dm_cache_tag_store #(
  parameter int LINES = 16,
  parameter int TAG_W = 9,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             fill_i,
  input  logic [TAG_W-1:0] fill_tag_i,
  input  logic             mark_dirty_i,
  output logic             valid_o,
  output logic             dirty_o,
  output logic [TAG_W-1:0] tag_o
);
  logic [LINES-1:0] valid_q, dirty_q;
  logic [TAG_W-1:0] tag_q [LINES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (fill_i) begin
      valid_q[idx_i] <= 1'b1;
      dirty_q[idx_i] <= 1'b0;
    end else if (mark_dirty_i) begin
      dirty_q[idx_i] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (fill_i) tag_q[idx_i] <= fill_tag_i;
  end

  assign valid_o = valid_q[idx_i];
  assign dirty_o = dirty_q[idx_i];
  assign tag_o   = tag_q[idx_i];
endmodule

// File: rtl/dm_cache_data_store.sv
module dm_cache_data_store #(
  parameter int LINES = 16,
  parameter int BYTES = 8,
  localparam int IDX_W = $clog2(LINES),
  localparam int DATA_W = 8 * BYTES
) (
  input  logic              clk_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              we_i,
  input  logic [BYTES-1:0]  be_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  // one array per byte lane, asynchronous read alongside the tag compare
  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    logic [7:0] lane_q [LINES];
    always_ff @(posedge clk_i) begin
      if (we_i && be_i[b]) lane_q[idx_i] <= wdata_i[8*b +: 8];
    end
    assign rdata_o[8*b +: 8] = lane_q[idx_i];
  end
endmodule

// File: rtl/dm_cache_counters.sv
module dm_cache_counters #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_inc_i,
  input  logic             miss_inc_i,
  output logic [CNT_W-1:0] acc_o,
  output logic [CNT_W-1:0] miss_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_o  <= '0;
      miss_o <= '0;
    end else begin
      if (acc_inc_i)  acc_o  <= acc_o + 1'b1;
      if (miss_inc_i) miss_o <= miss_o + 1'b1;
    end
  end
endmodule

// File: rtl/dm_cache_ctrl.sv
module dm_cache_ctrl
  import dm_cache_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int LINES       = 16,
  parameter int LINE_BYTES  = 8,
  parameter int CNT_W       = 16,
  parameter bit WRITE_BACK  = 1'b1,
  parameter bit WRITE_ALLOC = 1'b1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_valid_i,
  output logic                    req_ready_o,
  input  logic                    req_write_i,
  input  logic [ADDR_W-1:0]       req_addr_i,
  input  logic [8*LINE_BYTES-1:0] req_wdata_i,
  input  logic [LINE_BYTES-1:0]   req_be_i,
  output logic                    rsp_valid_o,
  output logic [8*LINE_BYTES-1:0] rsp_rdata_o,
  output logic                    mem_req_valid_o,
  input  logic                    mem_req_ready_i,
  output logic                    mem_req_write_o,
  output logic [ADDR_W-1:0]       mem_req_addr_o,
  output logic [8*LINE_BYTES-1:0] mem_req_wdata_o,
  output logic [LINE_BYTES-1:0]   mem_req_be_o,
  input  logic                    mem_rsp_valid_i,
  input  logic [8*LINE_BYTES-1:0] mem_rsp_rdata_i,
  output logic [CNT_W-1:0]        acc_cnt_o,
  output logic [CNT_W-1:0]        miss_cnt_o
);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int IDX_W  = $clog2(LINES);
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
  localparam int DATA_W = 8 * LINE_BYTES;

  cc_state_e state_q, state_d;
  logic              q_write;
  logic [IDX_W-1:0]  q_idx;
  logic [TAG_W-1:0]  q_tag;
  logic [DATA_W-1:0] q_wdata;
  logic [LINE_BYTES-1:0] q_be;
  logic              rd_pend_q;

  logic              line_valid, line_dirty;
  logic [TAG_W-1:0]  line_tag;
  logic [DATA_W-1:0] line_data;
  logic              hit, accept, fill_done, miss_inc;
  logic              ds_we;
  logic [LINE_BYTES-1:0] ds_be;
  logic [DATA_W-1:0] ds_wdata;
  logic              unused_off;

  assign unused_off  = ^req_addr_i[OFF_W-1:0];
  assign req_ready_o = (state_q == ST_IDLE);
  assign accept      = req_valid_i && req_ready_o;
  assign hit         = line_valid && (line_tag == q_tag);
  assign fill_done   = (state_q == ST_FILL) && rd_pend_q && mem_rsp_valid_i;
  assign rsp_rdata_o = line_data;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      rd_pend_q <= 1'b0;
      q_write   <= 1'b0;
      q_idx     <= '0;
      q_tag     <= '0;
      q_wdata   <= '0;
      q_be      <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        q_write <= req_write_i;
        q_idx   <= req_addr_i[OFF_W +: IDX_W];
        q_tag   <= req_addr_i[ADDR_W-1 -: TAG_W];
        q_wdata <= req_wdata_i;
        q_be    <= req_be_i;
      end
      if (fill_done) rd_pend_q <= 1'b0;
      else if (state_q == ST_FILL && mem_req_valid_o && mem_req_ready_i) rd_pend_q <= 1'b1;
    end
  end

  always_comb begin
    state_d         = state_q;
    rsp_valid_o     = 1'b0;
    mem_req_valid_o = 1'b0;
    mem_req_write_o = 1'b0;
    mem_req_addr_o  = {q_tag, q_idx, {OFF_W{1'b0}}};
    mem_req_wdata_o = '0;
    mem_req_be_o    = '0;
    miss_inc        = 1'b0;
    unique case (state_q)
      ST_IDLE: if (accept) state_d = ST_COMPARE;
      ST_COMPARE: begin
        if (hit) begin
          if (!q_write) begin
            rsp_valid_o = 1'b1;
            state_d     = ST_IDLE;
          end else begin
            state_d = ST_RESPOND;
          end
        end else begin
          miss_inc = 1'b1;
          if (q_write && !WRITE_ALLOC)                     state_d = ST_MEMWR;
          else if (WRITE_BACK && line_valid && line_dirty) state_d = ST_WRITEBACK;
          else                                             state_d = ST_FILL;
        end
      end
      ST_WRITEBACK: begin
        mem_req_valid_o = 1'b1;
        mem_req_write_o = 1'b1;
        mem_req_addr_o  = {line_tag, q_idx, {OFF_W{1'b0}}};
        mem_req_wdata_o = line_data;
        mem_req_be_o    = '1;
        if (mem_req_ready_i) state_d = ST_FILL;
      end
      ST_FILL: begin
        mem_req_valid_o = !rd_pend_q;
        if (fill_done) state_d = ST_COMPARE;  // retry now hits
      end
      ST_RESPOND: begin
        if (WRITE_BACK) begin
          rsp_valid_o = 1'b1;
          state_d     = ST_IDLE;
        end else begin
          state_d = ST_MEMWR;
        end
      end
      ST_MEMWR: begin
        mem_req_valid_o = 1'b1;
        mem_req_write_o = 1'b1;
        mem_req_wdata_o = q_wdata;
        mem_req_be_o    = q_be;
        if (mem_req_ready_i) begin
          rsp_valid_o = 1'b1;
          state_d     = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign ds_we    = fill_done || (state_q == ST_RESPOND);
  assign ds_be    = fill_done ? {LINE_BYTES{1'b1}} : q_be;
  assign ds_wdata = fill_done ? mem_rsp_rdata_i : q_wdata;

  dm_cache_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .idx_i       (q_idx),
    .fill_i      (fill_done),
    .fill_tag_i  (q_tag),
    .mark_dirty_i(WRITE_BACK && (state_q == ST_RESPOND)),
    .valid_o     (line_valid),
    .dirty_o     (line_dirty),
    .tag_o       (line_tag)
  );

  dm_cache_data_store #(.LINES(LINES), .BYTES(LINE_BYTES)) u_data (
    .clk_i  (clk_i),
    .idx_i  (q_idx),
    .we_i   (ds_we),
    .be_i   (ds_be),
    .wdata_i(ds_wdata),
    .rdata_o(line_data)
  );

  dm_cache_counters #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .acc_inc_i (accept),
    .miss_inc_i(miss_inc),
    .acc_o     (acc_cnt_o),
    .miss_o    (miss_cnt_o)
  );
endmodule

// File: rtl/dm_cache_ctrl_chk.sv
module dm_cache_ctrl_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 64,
  parameter int CNT_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              rsp_valid_o,
  input logic              mem_req_valid_o,
  input logic              mem_req_ready_i,
  input logic              mem_req_write_o,
  input logic [ADDR_W-1:0] mem_req_addr_o,
  input logic [DATA_W-1:0] mem_req_wdata_o,
  input logic [CNT_W-1:0]  acc_cnt_o,
  input logic [CNT_W-1:0]  miss_cnt_o
);
  // R9
  mem_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_req_addr_o)
      && $stable(mem_req_write_o) && $stable(mem_req_wdata_o));
  // R9
  busy_not_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> !req_ready_o);
  // R3
  single_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);
  // R10
  acc_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> acc_cnt_o == $past(acc_cnt_o) + 1'b1);
  // R10
  acc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_valid_i && req_ready_o) |=> $stable(acc_cnt_o));
  // R10
  miss_when_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miss_cnt_o != $past(miss_cnt_o)) |-> !$past(req_ready_o));
endmodule

bind dm_cache_ctrl dm_cache_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(8*LINE_BYTES), .CNT_W(CNT_W)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .req_valid_i    (req_valid_i),
  .req_ready_o    (req_ready_o),
  .rsp_valid_o    (rsp_valid_o),
  .mem_req_valid_o(mem_req_valid_o),
  .mem_req_ready_i(mem_req_ready_i),
  .mem_req_write_o(mem_req_write_o),
  .mem_req_addr_o (mem_req_addr_o),
  .mem_req_wdata_o(mem_req_wdata_o),
  .acc_cnt_o      (acc_cnt_o),
  .miss_cnt_o     (miss_cnt_o)
);

// File: tb/dm_cache_ctrl_test.sv
module dm_cache_ctrl_test;
  localparam int AW = 16, NL = 16, LB = 8, DW = 64, CW = 16, ML = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  // index 0: write-back + allocate, index 1: write-through + no-allocate
  logic          req_valid [2];
  logic          req_write [2];
  logic [AW-1:0] req_addr  [2];
  logic [DW-1:0] req_wdata [2];
  logic [LB-1:0] req_be    [2];
  logic          req_ready [2];
  logic          rsp_valid [2];
  logic [DW-1:0] rsp_rdata [2];
  logic          mreq_valid[2];
  logic          mreq_ready[2];
  logic          mreq_write[2];
  logic [AW-1:0] mreq_addr [2];
  logic [DW-1:0] mreq_wdata[2];
  logic [LB-1:0] mreq_be   [2];
  logic          mrsp_valid[2];
  logic [DW-1:0] mrsp_rdata[2];
  logic [CW-1:0] acc_cnt   [2];
  logic [CW-1:0] miss_cnt  [2];

  dm_cache_ctrl #(.ADDR_W(AW), .LINES(NL), .LINE_BYTES(LB), .CNT_W(CW),
                  .WRITE_BACK(1'b1), .WRITE_ALLOC(1'b1)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid[0]), .req_ready_o(req_ready[0]), .req_write_i(req_write[0]),
    .req_addr_i(req_addr[0]), .req_wdata_i(req_wdata[0]), .req_be_i(req_be[0]),
    .rsp_valid_o(rsp_valid[0]), .rsp_rdata_o(rsp_rdata[0]),
    .mem_req_valid_o(mreq_valid[0]), .mem_req_ready_i(mreq_ready[0]),
    .mem_req_write_o(mreq_write[0]), .mem_req_addr_o(mreq_addr[0]),
    .mem_req_wdata_o(mreq_wdata[0]), .mem_req_be_o(mreq_be[0]),
    .mem_rsp_valid_i(mrsp_valid[0]), .mem_rsp_rdata_i(mrsp_rdata[0]),
    .acc_cnt_o(acc_cnt[0]), .miss_cnt_o(miss_cnt[0]));

  dm_cache_ctrl #(.ADDR_W(AW), .LINES(NL), .LINE_BYTES(LB), .CNT_W(CW),
                  .WRITE_BACK(1'b0), .WRITE_ALLOC(1'b0)) uut_wt (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid[1]), .req_ready_o(req_ready[1]), .req_write_i(req_write[1]),
    .req_addr_i(req_addr[1]), .req_wdata_i(req_wdata[1]), .req_be_i(req_be[1]),
    .rsp_valid_o(rsp_valid[1]), .rsp_rdata_o(rsp_rdata[1]),
    .mem_req_valid_o(mreq_valid[1]), .mem_req_ready_i(mreq_ready[1]),
    .mem_req_write_o(mreq_write[1]), .mem_req_addr_o(mreq_addr[1]),
    .mem_req_wdata_o(mreq_wdata[1]), .mem_req_be_o(mreq_be[1]),
    .mem_rsp_valid_i(mrsp_valid[1]), .mem_rsp_rdata_i(mrsp_rdata[1]),
    .acc_cnt_o(acc_cnt[1]), .miss_cnt_o(miss_cnt[1]));

  int checks = 0, errors = 0;

  function automatic logic [DW-1:0] init_line(int d, int ln);
    return {16'hA5A5 ^ 16'(d), 16'(ln), 16'(ln * 7 + 3), 16'hC3C3};
  endfunction

  function automatic logic [DW-1:0] merge(logic [DW-1:0] old, logic [DW-1:0] nw, logic [LB-1:0] be);
    logic [DW-1:0] r = old;
    for (int b = 0; b < LB; b++) if (be[b]) r[8*b +: 8] = nw[8*b +: 8];
    return r;
  endfunction

  // memory model
  logic [DW-1:0] mem [2][ML];
  int            mwr_cnt [2];
  logic          pend [2];
  int            dly [2];
  logic [DW-1:0] hold [2];

  always @(negedge clk) begin
    for (int d = 0; d < 2; d++) begin
      if (!rst_n) begin
        for (int l = 0; l < ML; l++) mem[d][l] = init_line(d, l);
        mwr_cnt[d] = 0; pend[d] = 1'b0; dly[d] = 0;
        mreq_ready[d] = 1'b0; mrsp_valid[d] = 1'b0; mrsp_rdata[d] = '0;
      end else begin
        mrsp_valid[d] = 1'b0;
        if (pend[d]) begin
          if (dly[d] == 0) begin
            mrsp_valid[d] = 1'b1; mrsp_rdata[d] = hold[d]; pend[d] = 1'b0;
          end else dly[d]--;
        end
        mreq_ready[d] = ($urandom_range(0, 3) != 0);
        if (mreq_valid[d] && mreq_ready[d]) begin
          if (mreq_write[d]) begin
            mem[d][mreq_addr[d][3 +: 6]] = merge(mem[d][mreq_addr[d][3 +: 6]], mreq_wdata[d], mreq_be[d]);
            mwr_cnt[d]++;
          end else begin
            hold[d] = mem[d][mreq_addr[d][3 +: 6]];
            pend[d] = 1'b1;
            dly[d]  = $urandom_range(0, 2);
          end
        end
      end
    end
  end

  // reference model
  logic [DW-1:0] gold [2][ML];
  logic          m_vld [2][NL];
  logic          m_dty [2][NL];
  int            m_tag [2][NL];
  int            e_miss [2], e_acc [2], e_mw [2];

  task automatic check(bit ok, string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic access(int d, bit wr, int ln, logic [LB-1:0] be, logic [DW-1:0] wd,
                        output logic [DW-1:0] rd, output int lat);
    req_valid[d] = 1'b1; req_write[d] = wr; req_addr[d] = AW'(ln << 3);
    req_wdata[d] = wd; req_be[d] = be;
    while (!req_ready[d]) step();
    step();
    req_valid[d] = 1'b0;
    lat = 1;
    while (!rsp_valid[d] && lat < 500) begin step(); lat++; end
    rd = rsp_rdata[d];
    step();
  endtask

  task automatic op(int d, bit wr, int ln, logic [LB-1:0] be, logic [DW-1:0] wd);
    int idx = ln % NL, tg = ln / NL, lat;
    bit miss = !(m_vld[d][idx] && m_tag[d][idx] == tg);
    logic [DW-1:0] rd;
    if (d == 0) begin
      if (miss) begin
        if (m_vld[d][idx] && m_dty[d][idx]) e_mw[d]++;
        m_vld[d][idx] = 1'b1; m_tag[d][idx] = tg; m_dty[d][idx] = 1'b0;
      end
      if (wr) m_dty[d][idx] = 1'b1;
    end else begin
      if (wr) e_mw[d]++;
      else if (miss) begin m_vld[d][idx] = 1'b1; m_tag[d][idx] = tg; end
    end
    if (wr) gold[d][ln] = merge(gold[d][ln], wd, be);
    if (miss) e_miss[d]++;
    e_acc[d]++;
    access(d, wr, ln, be, wd, rd, lat);
    if (!wr) check(rd === gold[d][ln], "R11 read data", rd, gold[d][ln]);
    if (!wr && !miss) check(lat == 1, "R3 read hit latency", DW'(lat), 1);
    if (wr && !miss && d == 0) check(lat == 2, "R4 write hit latency", DW'(lat), 2);
    check(miss_cnt[d] == CW'(e_miss[d]), "R10 R2 miss count", DW'(miss_cnt[d]), DW'(e_miss[d]));
    check(acc_cnt[d] == CW'(e_acc[d]), "R10 access count", DW'(acc_cnt[d]), DW'(e_acc[d]));
    check(mwr_cnt[d] == e_mw[d], d == 0 ? "R5 memory writes" : "R6 memory writes",
          DW'(mwr_cnt[d]), DW'(e_mw[d]));
    if (d == 1 && wr) check(mem[1][ln] === gold[1][ln], "R6 memory content", mem[1][ln], gold[1][ln]);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    for (int d = 0; d < 2; d++) begin
      req_valid[d] = 1'b0; req_write[d] = 1'b0; req_addr[d] = '0;
      req_wdata[d] = '0; req_be[d] = '0;
      e_miss[d] = 0; e_acc[d] = 0; e_mw[d] = 0;
      for (int l = 0; l < ML; l++) gold[d][l] = init_line(d, l);
      for (int i = 0; i < NL; i++) begin m_vld[d][i] = 1'b0; m_dty[d][i] = 1'b0; m_tag[d][i] = 0; end
    end
    repeat (3) step();
    rst_n = 1'b1;
    step();
    for (int d = 0; d < 2; d++) begin
      // R1
      check(req_ready[d] === 1'b1, "R1 ready after reset", DW'(req_ready[d]), 1);
      check(acc_cnt[d] == 0 && miss_cnt[d] == 0, "R1 counters zero", DW'({acc_cnt[d], miss_cnt[d]}), 0);
      check(mreq_valid[d] === 1'b0, "R1 no memory request", DW'(mreq_valid[d]), 0);
    end
    // write-back, write-allocate directed: R5 R7 R2 R4
    op(0, 0, 5, '0, '0);
    op(0, 0, 5, '0, '0);
    op(0, 1, 5, 8'h0F, 64'h1111_2222_3333_4444);
    op(0, 0, 21, '0, '0);                       // dirty victim written back
    op(0, 0, 5, '0, '0);                        // clean victim dropped
    op(0, 1, 37, 8'h81, 64'hDEAD_0000_0000_BEEF); // R7 allocate on write miss
    op(0, 0, 37, '0, '0);
    // write-through, no-write-allocate directed: R6 R8
    op(1, 0, 2, '0, '0);
    op(1, 1, 18, 8'hF0, 64'hAAAA_BBBB_CCCC_DDDD); // R8 bypass
    op(1, 0, 2, '0, '0);                         // R8 old line still hits
    op(1, 0, 18, '0, '0);
    op(1, 1, 18, 8'h3C, 64'h0123_4567_89AB_CDEF); // R6 write hit
    // constrained random
    for (int n = 0; n < 600; n++) begin
      int d = n % 2;
      bit wr = ($urandom_range(0, 2) == 0);
      logic [LB-1:0] be = LB'($urandom_range(1, 255));
      op(d, wr, $urandom_range(0, ML - 1), be, {$urandom, $urandom});
    end
    finish_run();
  end
endmodule